// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This block sits after instruction decode and resolves one operand per request. A request carries a 4-bit mode code, a 16-bit field (an address or a constant) and a register index. The unit reads a small external register file through a combinational read port and issues word accesses to an external synchronous memory, one access per cycle. It returns the effective address and the operand, and it keeps a downward-growing stack pointer of its own.

Requests enter through a valid/ready handshake. The unit accepts a request only when it is idle, so `in_ready` is low from acceptance until the result is taken. The result is presented with `out_valid`. It stays valid and unchanged until `out_ready` is sampled high, and no new request is accepted while a result is waiting. Short modes finish one clock after acceptance, single-access modes after two, and the two-access modes after three.

Address arithmetic wraps modulo 2^16. Memory read data arrives one cycle after the read strobe.

Top module: `eau_top`

## Requirements
- R1: After reset the stack pointer reads 0xFFFF, `out_valid` is low and `in_ready` is high. While idle the unit makes no memory access.
- R2: Mode 0 (immediate) returns the field as the operand and 0 as the address, with no memory access, one clock after acceptance.
- R3: Mode 1 (direct) returns address = field and operand = memory at the field, using one read, two clocks after acceptance.
- R4: Mode 2 (indirect) reads the word at the field as a pointer and then reads the operand at that pointer. The address is the pointer, it takes two reads, and it finishes three clocks after acceptance.
- R5: Mode 3 (register) returns the selected register as the operand and 0 as the address, with no memory access.
- R6: Mode 4 (register indirect) uses the selected register's content as the address and reads the operand there.
- R7: Mode 5 (displacement) uses field + register (mod 2^16) as the address and reads the operand there.
- R8: Mode 6 (pre-index) forms field + register first. The word read at that sum is the address, and the operand is read from it.
- R9: Mode 7 (post-index) reads the word at the field and adds the register to it. The sum is the address, and the operand is read from it.
- R10: Mode 8 (push) decrements the stack pointer and then writes the selected register at the new pointer. It returns that pointer as the address and the written value as the operand.
- R11: Mode 9 (pop) reads the operand at the current stack pointer, returns that pointer as the address, and increments the pointer, wrapping from 0xFFFF to 0x0000.
- R12: Codes 10 to 15 raise `out_illegal` with the result, return address and operand 0, make no memory access and leave the stack pointer unchanged.
- R13: `in_ready` is high only when the unit is idle and no result is pending. A result that is not taken holds `out_valid`, `out_ea` and `out_operand` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit idle, request accepted on valid |
| in_mode | input | 4 | Addressing mode code |
| in_field | input | 16 | Address or constant field |
| in_reg | input | 3 | Register index |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_ea | output | 16 | Effective address |
| out_operand | output | 16 | Resolved operand |
| out_illegal | output | 1 | Mode code was not recognised |
| sp | output | 16 | Current stack pointer |
| rf_addr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the strobe |

## Verification
Each mode is driven with fields and register values chosen so that confusing one order of indexing and indirection with the other gives a different address. The pre-index and post-index cases use the same field and register, which means only the right order yields the expected pointer. A displacement whose sum crosses 0xFFFF separates wrapping from carry-out. Consecutive pushes and pops, plus a pop at 0xFFFF, show last-in-first-out order and wrap of the stack pointer. Illegal codes and held results show that nothing moves while a result waits or a code is rejected.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int MW = 4;

  localparam logic [MW-1:0] MD_IMM  = 4'd0;
  localparam logic [MW-1:0] MD_DIR  = 4'd1;
  localparam logic [MW-1:0] MD_IND  = 4'd2;
  localparam logic [MW-1:0] MD_REG  = 4'd3;
  localparam logic [MW-1:0] MD_RIND = 4'd4;
  localparam logic [MW-1:0] MD_DISP = 4'd5;
  localparam logic [MW-1:0] MD_PRE  = 4'd6;
  localparam logic [MW-1:0] MD_POST = 4'd7;
  localparam logic [MW-1:0] MD_PUSH = 4'd8;
  localparam logic [MW-1:0] MD_POP  = 4'd9;

  typedef enum logic [2:0] {ST_IDLE, ST_CALC, ST_PTR, ST_OP, ST_DONE} st_e;
  typedef enum logic [1:0] {NX_DONE, NX_OP, NX_PTR} nx_e;
endpackage

// File: rtl/eau_sp.sv
module eau_sp #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  output logic [DW-1:0] sp_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp_o <= '1;
    else if (dec) sp_o <= sp_o - DW'(1);
    else if (inc) sp_o <= sp_o + DW'(1);
  end
endmodule

// File: rtl/eau_step.sv
module eau_step import eau_pkg::*; #(
  parameter int DW = 16
) (
  input  logic [MW-1:0] mode,
  input  logic [DW-1:0] fld,
  input  logic [DW-1:0] rv,
  input  logic [DW-1:0] sp,
  output logic          rd,
  output logic          wr,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] opnd,
  output nx_e           nx,
  output logic          sp_dec,
  output logic          sp_inc,
  output logic          ill
);
  logic [DW-1:0] sum_fr;
  logic [DW-1:0] sp_m1;

  assign sum_fr = fld + rv;
  assign sp_m1  = sp - DW'(1);

  always_comb begin
    rd     = 1'b0;
    wr     = 1'b0;
    addr   = fld;
    wdata  = '0;
    ea     = '0;
    opnd   = '0;
    nx     = NX_DONE;
    sp_dec = 1'b0;
    sp_inc = 1'b0;
    ill    = 1'b0;
    case (mode)
      MD_IMM: opnd = fld;
      MD_DIR: begin
        rd = 1'b1; addr = fld; ea = fld; nx = NX_OP;
      end
      MD_IND: begin
        rd = 1'b1; addr = fld; ea = fld; nx = NX_PTR;
      end
      MD_REG: opnd = rv;
      MD_RIND: begin
        rd = 1'b1; addr = rv; ea = rv; nx = NX_OP;
      end
      MD_DISP: begin
        rd = 1'b1; addr = sum_fr; ea = sum_fr; nx = NX_OP;
      end
      MD_PRE: begin
        rd = 1'b1; addr = sum_fr; ea = sum_fr; nx = NX_PTR;
      end
      MD_POST: begin
        rd = 1'b1; addr = fld; ea = fld; nx = NX_PTR;
      end
      MD_PUSH: begin
        wr = 1'b1; addr = sp_m1; wdata = rv; ea = sp_m1; opnd = rv;
        sp_dec = 1'b1;
      end
      MD_POP: begin
        rd = 1'b1; addr = sp; ea = sp; nx = NX_OP; sp_inc = 1'b1;
      end
      default: ill = 1'b1;
    endcase
  end
endmodule

// File: rtl/eau_ptr.sv
module eau_ptr #(
  parameter int DW = 16
) (
  input  logic          post,
  input  logic [DW-1:0] ptr,
  input  logic [DW-1:0] rv,
  output logic [DW-1:0] ea
);
  logic [DW-1:0] idx;
  assign idx = post ? rv : '0;
  assign ea  = ptr + idx;
endmodule

// File: rtl/eau_top.sv
module eau_top import eau_pkg::*; #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [MW-1:0]  in_mode,
  input  logic [DW-1:0]  in_field,
  input  logic [RIW-1:0] in_reg,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_ea,
  output logic [DW-1:0]  out_operand,
  output logic           out_illegal,
  output logic [DW-1:0]  sp,
  output logic [RIW-1:0] rf_addr,
  input  logic [DW-1:0]  rf_rdata,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);
  st_e            st_q;
  logic [MW-1:0]  mode_q;
  logic [DW-1:0]  fld_q;
  logic [RIW-1:0] reg_q;
  logic [DW-1:0]  ea_q;
  logic [DW-1:0]  opnd_q;
  logic           ill_q;

  logic           s_rd, s_wr, s_dec, s_inc, s_ill;
  logic [DW-1:0]  s_addr, s_wdata, s_ea, s_opnd;
  nx_e            s_nx;
  logic [DW-1:0]  ptr_ea;
  logic           calc_en;

  assign calc_en = (st_q == ST_CALC);
  assign rf_addr = reg_q;

  eau_step #(.DW(DW)) u_step (
    .mode  (mode_q),
    .fld   (fld_q),
    .rv    (rf_rdata),
    .sp    (sp),
    .rd    (s_rd),
    .wr    (s_wr),
    .addr  (s_addr),
    .wdata (s_wdata),
    .ea    (s_ea),
    .opnd  (s_opnd),
    .nx    (s_nx),
    .sp_dec(s_dec),
    .sp_inc(s_inc),
    .ill   (s_ill)
  );

  eau_ptr #(.DW(DW)) u_ptr (
    .post(mode_q == MD_POST),
    .ptr (mem_rdata),
    .rv  (rf_rdata),
    .ea  (ptr_ea)
  );

  eau_sp #(.DW(DW)) u_sp (
    .clk (clk),
    .rst_n(rst_n),
    .dec (calc_en & s_dec),
    .inc (calc_en & s_inc),
    .sp_o(sp)
  );

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = ea_q;
    mem_wdata = '0;
    case (st_q)
      ST_CALC: begin
        mem_rd    = s_rd;
        mem_wr    = s_wr;
        mem_addr  = s_addr;
        mem_wdata = s_wdata;
      end
      ST_PTR: begin
        mem_rd   = 1'b1;
        mem_addr = ptr_ea;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      fld_q  <= '0;
      reg_q  <= '0;
      ea_q   <= '0;
      opnd_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (in_valid) begin
          mode_q <= in_mode;
          fld_q  <= in_field;
          reg_q  <= in_reg;
          st_q   <= ST_CALC;
        end
        ST_CALC: begin
          ea_q   <= s_ea;
          opnd_q <= s_opnd;
          ill_q  <= s_ill;
          case (s_nx)
            NX_OP:   st_q <= ST_OP;
            NX_PTR:  st_q <= ST_PTR;
            default: st_q <= ST_DONE;
          endcase
        end
        ST_PTR: begin
          ea_q <= ptr_ea;
          st_q <= ST_OP;
        end
        ST_OP: begin
          opnd_q <= mem_rdata;
          st_q   <= ST_DONE;
        end
        ST_DONE: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready    = (st_q == ST_IDLE);
  assign out_valid   = (st_q == ST_DONE);
  assign out_ea      = ea_q;
  assign out_operand = opnd_q;
  assign out_illegal = out_valid & ill_q;
endmodule

// File: rtl/eau_chk.sv
module eau_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_ea,
  input logic [DW-1:0] out_operand,
  input logic [DW-1:0] sp,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_addr
);
  // R13: never ready while a result is pending
  p_ready_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R13: untaken result is held
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ea) && $stable(out_operand)));

  // R1: idle means no memory traffic
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mem_rd && !mem_wr));

  // R10: a write and a read never share a cycle
  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R10: the push write lands one below the current pointer
  p_push_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == sp - DW'(1)));

  // R11: stack pointer moves by at most one per cycle
  p_sp_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> ((sp == $past(sp) - DW'(1)) || (sp == $past(sp) + DW'(1))));
endmodule

bind eau_top eau_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_ea     (out_ea),
  .out_operand(out_operand),
  .sp         (sp),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr)
);

// File: tb/sim_eau_top.sv
module sim_eau_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_mode = '0;
  logic [15:0] in_field = '0;
  logic [2:0]  in_reg = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_ea, out_operand, sp;
  logic        out_illegal;
  logic [2:0]  rf_addr;
  logic [15:0] rf_rdata;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata;

  logic [15:0] mem [256];
  logic [15:0] rm  [256];
  logic [15:0] rf  [8];
  int nrd = 0, nwr = 0;
  logic [15:0] lw_addr, lw_data;
  int checks = 0, errors = 0;
  logic [15:0] sp_e = 16'hFFFF;
  bit finished = 0;

  always #2 clk = ~clk;

  eau_top u0 (.*);

  assign rf_rdata = rf[rf_addr];

  function automatic logic [15:0] pat(int i);
    return 16'(i * 291 + 64);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      mem_rdata <= '0;
    end else begin
      if (mem_rd) begin
        mem_rdata <= mem[mem_addr[7:0]];
        nrd <= nrd + 1;
      end
      if (mem_wr) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        nwr <= nwr + 1;
        lw_addr <= mem_addr;
        lw_data <= mem_wdata;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(logic [3:0] m, logic [15:0] a, int r, bit hold, string req);
    logic [15:0] rv, ea, op, t, sp_b;
    int lat, er, ew, rd0, wr0;
    bit ill;
    rv = rf[r]; ill = 0; er = 0; ew = 0; ea = 0; op = 0; lat = 1;
    sp_b = sp_e;
    case (m)
      4'd0: op = a;
      4'd1: begin ea = a; op = rm[ea[7:0]]; lat = 2; er = 1; end
      4'd2: begin ea = rm[a[7:0]]; op = rm[ea[7:0]]; lat = 3; er = 2; end
      4'd3: op = rv;
      4'd4: begin ea = rv; op = rm[ea[7:0]]; lat = 2; er = 1; end
      4'd5: begin ea = a + rv; op = rm[ea[7:0]]; lat = 2; er = 1; end
      4'd6: begin t = a + rv; ea = rm[t[7:0]]; op = rm[ea[7:0]]; lat = 3; er = 2; end
      4'd7: begin ea = rm[a[7:0]] + rv; op = rm[ea[7:0]]; lat = 3; er = 2; end
      4'd8: begin sp_e = sp_e - 16'd1; ea = sp_e; op = rv; rm[sp_e[7:0]] = rv; ew = 1; end
      4'd9: begin ea = sp_e; op = rm[sp_e[7:0]]; sp_e = sp_e + 16'd1; lat = 2; er = 1; end
      default: ill = 1;
    endcase
    rd0 = nrd; wr0 = nwr;
    @(negedge clk);
    chk(in_ready == 1'b1, "R13", 32'(in_ready), 1, "in_ready idle");
    in_valid = 1'b1; in_mode = m; in_field = a; in_reg = 3'(r);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R13", 32'(in_ready), 0, "in_ready busy");
    chk(out_valid == 1'b0, req, 32'(out_valid), 0, "early valid");
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      chk(out_valid == (k == lat), req, 32'(out_valid), 32'(k == lat), "valid timing");
      chk(sp == sp_e, req, 32'(sp), 32'(sp_e), "stack pointer");
    end
    chk(out_ea == ea, req, 32'(out_ea), 32'(ea), "address");
    chk(out_operand == op, req, 32'(out_operand), 32'(op), "operand");
    chk(out_illegal == ill, req, 32'(out_illegal), 32'(ill), "illegal flag");
    chk(nrd - rd0 == er, req, 32'(nrd - rd0), 32'(er), "read count");
    chk(nwr - wr0 == ew, req, 32'(nwr - wr0), 32'(ew), "write count");
    if (ew == 1) begin
      chk(lw_addr == ea, req, 32'(lw_addr), 32'(ea), "push addr");
      chk(lw_data == rv, req, 32'(lw_data), 32'(rv), "push data");
    end
    if (ill) chk(sp == sp_b, req, 32'(sp), 32'(sp_b), "sp unchanged");
    if (hold) begin
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(out_valid && out_ea == ea && out_operand == op, "R13",
            {out_valid, 15'd0, out_operand}, {1'b1, 15'd0, op}, "held result");
        chk(in_ready == 1'b0, "R13", 32'(in_ready), 0, "no accept while held");
      end
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R13", 32'(out_valid), 0, "valid drops after take");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rm[i] = pat(i);
    rf[0] = 16'h1111; rf[1] = 16'h0003; rf[2] = 16'h0030; rf[3] = 16'h0025;
    rf[4] = 16'hBEEF; rf[5] = 16'hCAFE; rf[6] = 16'h0002; rf[7] = 16'h7777;
    repeat (3) @(negedge clk);
    chk(sp == 16'hFFFF, "R1", 32'(sp), 32'hFFFF, "reset sp");
    chk(out_valid == 1'b0, "R1", 32'(out_valid), 0, "reset valid");
    chk(in_ready == 1'b1, "R1", 32'(in_ready), 1, "reset ready");
    rst_n = 1'b1;
    @(negedge clk);
    run_op(4'd0, 16'h1234, 0, 0, "R2");
    run_op(4'd0, 16'hFFFF, 5, 1, "R2");
    run_op(4'd3, 16'h0055, 7, 0, "R5");
    run_op(4'd1, 16'h0010, 0, 0, "R3");
    run_op(4'd2, 16'h0020, 0, 1, "R4");
    run_op(4'd4, 16'h0000, 2, 0, "R6");
    run_op(4'd5, 16'hFFF0, 3, 0, "R7");
    run_op(4'd5, 16'h0040, 6, 0, "R7");
    run_op(4'd6, 16'h0005, 1, 0, "R8");
    run_op(4'd7, 16'h0005, 1, 0, "R9");
    run_op(4'd6, 16'h0031, 6, 0, "R8");
    run_op(4'd7, 16'h0031, 6, 1, "R9");
    run_op(4'd8, 16'h0000, 4, 1, "R10");
    run_op(4'd8, 16'h0000, 5, 0, "R10");
    run_op(4'd10, 16'h0042, 1, 0, "R12");
    run_op(4'd9, 16'h0000, 0, 0, "R11");
    run_op(4'd9, 16'h0000, 0, 0, "R11");
    run_op(4'd9, 16'h0000, 0, 0, "R11");
    run_op(4'd15, 16'h0099, 2, 1, "R12");
    run_op(4'd1, 16'h00FE, 0, 0, "R3");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R13 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule